// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block sits between a group of peripheral interrupt flags and a small 8-bit CPU. Each source is gated by its own enable bit and by a shared master enable. Each source is also placed on one of four priority levels, which are set by two configuration bits per source. From the sources that are both pending and allowed, the controller picks the best one. It then raises a registered request with the index of that source as the vector.

The controller keeps a short record of the priority levels whose handlers have been entered and not yet left. An acknowledge from the CPU takes the granted request and enters its level into the record. A return strobe removes the most recent entry. A new request is raised only if its level is strictly above the innermost level in service, so a running handler is pre-empted only by a more urgent one. The peripherals clear their own flags.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source whose enable bit is low is never requested, even while its pending flag is high.
- R2: While the master enable is low, no request is raised, whatever the per-source enables are.
- R3: The level of source i is 2*prio_hi_i[i] + prio_lo_i[i]. Level 3 is the most urgent and level 0 the least. A pending source at a higher level wins over any source at a lower level, whatever their indices.
- R4: Among eligible sources on the same best level, the one with the smallest index is granted.
- R5: While a handler is in service, a source at the same level or a lower level does not raise a request. A source at a strictly higher level does.
- R6: An acknowledge records the granted level as the innermost in-service level. A return strobe discards the innermost entry. Sources that were blocked are then judged against the level now exposed, and when the record is empty any eligible source may be requested.
- R7: Once the request is raised, vec_o keeps its value until the acknowledge, even if a more urgent source becomes pending in the meantime.
- R8: If the requested source stops being eligible before the acknowledge, req_o falls at the next clock edge and the in-service record is not changed.
- R9: req_o rises at the first clock edge at which a grantable source is sampled. It falls at the edge that samples ack_i high.
- R10: After reset, req_o is low and no level is in service.
- R11: A return strobe when nothing is in service has no effect. An acknowledge while req_o is low records nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | NUM_SRC | Pending flags from the sources |
| en_i | input | NUM_SRC | Per-source enable bits |
| glob_en_i | input | 1 | Master enable |
| prio_lo_i | input | NUM_SRC | Low bit of each source's level |
| prio_hi_i | input | NUM_SRC | High bit of each source's level |
| ack_i | input | 1 | CPU takes the current request |
| reti_i | input | 1 | CPU leaves the innermost handler |
| req_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | IDX_W | Index of the requested source |

## Verification
A corrupted in-service record does not show up until the next request is judged. An entry that was pushed but should not have been blocks a source at the same or a lower level. An entry that was popped but should not have been lets an equal-level source pre-empt. Either error appears at req_o one or two edges after the stimulus that follows the fault. The bench therefore follows every withdrawal, stray acknowledge and stray return with a low-level source, which reveals the record at once. A wrong arbitration choice, or a vector that moves while it should be held, appears on vec_o in the cycle after the request rises.

// File: rtl/irq_prio_pkg.sv
// Package: shared level type and level count for the interrupt priority controller.
// Assumes exactly four levels, encoded in two bits, where a larger value is more urgent.
package irq_prio_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_level_arbiter.sv
// Module: irq_level_arbiter
// Purely combinational. Finds the most urgent level among the eligible sources, and
// the lowest-index eligible source on that level.
// Assumes elig_i has already been gated by the enables.
module irq_level_arbiter
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] elig_i,
    input  lvl_t               lvl_i [NUM_SRC],
    output logic               any_o,
    output lvl_t               best_lvl_o,
    output logic [IDX_W-1:0]   best_idx_o
);
    logic [NUM_SRC-1:0] lvl_mask [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_hit;
    logic [NUM_SRC-1:0] win_mask;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        // Sources that are eligible and sit on level l.
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                lvl_mask[l][i] = elig_i[i] && (lvl_i[i] == lvl_t'(l));
            end
        end
        assign lvl_hit[l] = |lvl_mask[l];
    end

    // Pick the highest level that has at least one eligible source.
    always_comb begin
        best_lvl_o = '0;
        win_mask   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_hit[l]) begin
                best_lvl_o = lvl_t'(l);
                win_mask   = lvl_mask[l];
            end
        end
    end

    // Lowest set index within the winning level; the loop runs downward so the smallest index is kept.
    always_comb begin
        best_idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (win_mask[i]) best_idx_o = IDX_W'(i);
        end
    end

    assign any_o = |lvl_hit;
endmodule

// File: rtl/irq_service_stack.sv
// Module: irq_service_stack
// Last-in first-out record of the levels whose handlers are in service.
// Pop when empty is ignored, and so is push when full. Push and pop in the same
// cycle replace the top entry (or just push when the record is empty).
// Assumes DEPTH >= 1; synchronous active-low reset empties the record.
module irq_service_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  lvl_t push_lvl_i,
    input  logic pop_i,
    output logic busy_o,
    output lvl_t top_lvl_o
);
    lvl_t             entry [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             empty, full;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    // Update the entry count for push, pop or replace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push_i && pop_i) begin
            if (empty) cnt_q <= cnt_q + 1'b1;
        end else if (push_i && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop_i && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    for (genvar d = 0; d < DEPTH; d++) begin : g_ent
        // Write slot d on a push into it, or on a replace of the top when d is the top.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[d] <= '0;
            end else if (push_i && pop_i && !empty) begin
                if (cnt_q == CNT_W'(d + 1)) entry[d] <= push_lvl_i;
            end else if (push_i && !full && !(pop_i && !empty)) begin
                if (cnt_q == CNT_W'(d)) entry[d] <= push_lvl_i;
            end
        end
    end

    // Present the most recent entry.
    always_comb begin
        top_lvl_o = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (cnt_q == CNT_W'(d + 1)) top_lvl_o = entry[d];
        end
    end

    assign busy_o = !empty;
endmodule

// File: rtl/irq_req_hold.sv
// Module: irq_req_hold
// Registers the request. It latches vector and level when a grant is allowed and
// holds them until the acknowledge. It withdraws when the held source is no longer eligible.
// Assumes elig_i is the gated pending vector seen by the arbiter.
module irq_req_hold
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_ok_i,
    input  logic [IDX_W-1:0]   best_idx_i,
    input  lvl_t               best_lvl_i,
    input  logic [NUM_SRC-1:0] elig_i,
    input  logic               ack_i,
    output logic               req_o,
    output logic [IDX_W-1:0]   vec_o,
    output lvl_t               lvl_o,
    output logic               taken_o
);
    logic held_alive;

    // The held source is still pending and still enabled.
    assign held_alive = elig_i[vec_o];
    assign taken_o    = req_o && ack_i;

    // Raise, hold, withdraw or retire the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            vec_o <= '0;
            lvl_o <= '0;
        end else if (req_o) begin
            if (ack_i || !held_alive) req_o <= 1'b0;
        end else if (grant_ok_i) begin
            req_o <= 1'b1;
            vec_o <= best_idx_i;
            lvl_o <= best_lvl_i;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: irq_prio_ctrl (top)
// Four-level interrupt priority controller with nested in-service tracking.
// Assumes the CPU pulses ack_i for one cycle while req_o is high, and pulses reti_i once per handler exit.
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DEPTH   = NUM_LVL,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               glob_en_i,
    input  logic [NUM_SRC-1:0] prio_lo_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               req_o,
    output logic [IDX_W-1:0]   vec_o
);
    logic [NUM_SRC-1:0] elig;
    lvl_t               src_lvl [NUM_SRC];
    logic               any_elig, busy, grant_ok, taken;
    lvl_t               best_lvl, top_lvl, held_lvl;
    logic [IDX_W-1:0]   best_idx;

    // Gate pending flags by both enables.
    assign elig = pend_i & en_i & {NUM_SRC{glob_en_i}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_lvl[i] = {prio_hi_i[i], prio_lo_i[i]};
    end

    irq_level_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .elig_i     (elig),
        .lvl_i      (src_lvl),
        .any_o      (any_elig),
        .best_lvl_o (best_lvl),
        .best_idx_o (best_idx)
    );

    // Only a strictly more urgent level than the innermost in-service one may be requested.
    assign grant_ok = any_elig && (!busy || (best_lvl > top_lvl));

    irq_req_hold #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_ok_i (grant_ok),
        .best_idx_i (best_idx),
        .best_lvl_i (best_lvl),
        .elig_i     (elig),
        .ack_i      (ack_i),
        .req_o      (req_o),
        .vec_o      (vec_o),
        .lvl_o      (held_lvl),
        .taken_o    (taken)
    );

    irq_service_stack #(.DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (taken),
        .push_lvl_i (held_lvl),
        .pop_i      (reti_i),
        .busy_o     (busy),
        .top_lvl_o  (top_lvl)
    );
endmodule

// File: rtl/irq_prio_chk.sv
// Module: irq_prio_chk
// Port-level temporal checks for irq_prio_ctrl, attached by bind.
module irq_prio_chk #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic               glob_en_i,
    input logic               ack_i,
    input logic               req_o,
    input logic [IDX_W-1:0]   vec_o
);
    // R1
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && ((pend_i & en_i) == '0)) |=> !req_o);

    // R2
    glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !glob_en_i) |=> !req_o);

    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && pend_i[vec_o] && en_i[vec_o] && glob_en_i) |=> (req_o && $stable(vec_o)));

    // R8
    withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !pend_i[vec_o]) |=> !req_o);

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend_i),
    .en_i      (en_i),
    .glob_en_i (glob_en_i),
    .ack_i     (ack_i),
    .req_o     (req_o),
    .vec_o     (vec_o)
);

// File: tb/tb_irq_prio_ctrl.sv
// Directed bench for irq_prio_ctrl: one task per scenario, each checks its own results.
module tb_irq_prio_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pend = '0, en = '0, plo = '0, phi = '0;
    logic         gen = 1'b0, ack = 1'b0, reti = 1'b0;
    logic         req;
    logic [2:0]   vec;
    int           errors = 0, checks = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .glob_en_i(gen),
        .prio_lo_i(plo), .prio_hi_i(phi), .ack_i(ack), .reti_i(reti),
        .req_o(req), .vec_o(vec)
    );

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_req(string tag, bit exp_req, int exp_vec = -1);
        chk(req == exp_req, {tag, " req"}, req, exp_req);
        if (exp_req && exp_vec >= 0) chk(int'(vec) == exp_vec, {tag, " vec"}, vec, exp_vec);
    endtask

    task automatic set_lvl(int i, int l);
        plo[i] = l[0];
        phi[i] = l[1];
    endtask

    task automatic pulse_ack();  ack = 1'b1;  step(); ack = 1'b0;  endtask
    task automatic pulse_reti(); reti = 1'b1; step(); reti = 1'b0; endtask

    task automatic t_reset();
        chk_req("R10 reset", 1'b0);
        pend = '1; en = '1; gen = 1'b0;   // master off: nothing may appear
        step(2);
        chk_req("R10 idle after reset", 1'b0);
        pend = '0;
    endtask

    task automatic t_enable();
        gen = 1'b1; en = '0; set_lvl(2, 1);
        pend[2] = 1'b1;
        step(2);
        chk_req("R1 disabled source", 1'b0);
        en[2] = 1'b1;
        step();
        chk_req("R9 raised one edge later", 1'b1, 2);
        en[2] = 1'b0;
        step();
        chk_req("R1 enable dropped", 1'b0);
        pend[2] = 1'b0; en = '1;
    endtask

    task automatic t_global();
        gen = 1'b0; pend[5] = 1'b1; set_lvl(5, 0);
        step(2);
        chk_req("R2 master off", 1'b0);
        gen = 1'b1;
        step();
        chk_req("R2 master on", 1'b1, 5);
        pend[5] = 1'b0;
        step();
    endtask

    task automatic t_prio();
        set_lvl(1, 1); set_lvl(6, 3);
        pend[1] = 1'b1; pend[6] = 1'b1;
        step();
        chk_req("R3 higher level beats lower index", 1'b1, 6);
        pend = '0;
        step();
    endtask

    task automatic t_tie();
        set_lvl(3, 2); set_lvl(5, 2); set_lvl(0, 1);
        pend[0] = 1'b1; pend[3] = 1'b1; pend[5] = 1'b1;
        step();
        chk_req("R4 tie on level 2", 1'b1, 3);
        pend = '0;
        step();
    endtask

    task automatic t_nest();
        set_lvl(0, 1); set_lvl(7, 0); set_lvl(2, 2); set_lvl(4, 1);
        pend[0] = 1'b1;
        step();
        chk_req("R9 src0", 1'b1, 0);
        pulse_ack();
        chk_req("R9 drop on ack", 1'b0);
        pend[4] = 1'b1; pend[7] = 1'b1;
        step(3);
        chk_req("R5 equal and lower wait", 1'b0);
        pend[2] = 1'b1;
        step();
        chk_req("R5 higher pre-empts", 1'b1, 2);
        pulse_ack();
        pend[2] = 1'b0;
        pulse_reti();
        step();
        chk_req("R6 level 1 exposed, equal waits", 1'b0);
        pend[0] = 1'b0; pend[4] = 1'b0;
        pulse_reti();
        step();
        chk_req("R6 empty record releases level 0", 1'b1, 7);
        pulse_ack();
        pend[7] = 1'b0;
        pulse_reti();
        step();
    endtask

    task automatic t_hold();
        set_lvl(4, 1); set_lvl(1, 3);
        pend[4] = 1'b1;
        step();
        chk_req("R7 first request", 1'b1, 4);
        pend[1] = 1'b1;
        step(2);
        chk_req("R7 vector held", 1'b1, 4);
        pulse_ack();
        pend[4] = 1'b0;
        step();
        chk_req("R5 level 3 over level 1", 1'b1, 1);
        pulse_ack();
        pend[1] = 1'b0;
        pulse_reti(); pulse_reti();
        step();
    endtask

    task automatic t_withdraw();
        set_lvl(5, 1); set_lvl(3, 2); set_lvl(6, 0);
        pend[5] = 1'b1;
        step();
        pulse_ack();
        pend[5] = 1'b0;
        pend[3] = 1'b1;
        step();
        chk_req("R8 level 2 requested", 1'b1, 3);
        pend[3] = 1'b0;
        step();
        chk_req("R8 withdrawn", 1'b0);
        pulse_reti();
        pend[6] = 1'b1;
        step();
        chk_req("R8 record untouched", 1'b1, 6);
        pulse_ack();
        pend[6] = 1'b0;
        pulse_reti();
        step();
    endtask

    task automatic t_spurious();
        set_lvl(2, 0);
        pulse_reti();
        pulse_ack();
        step();
        chk_req("R11 still idle", 1'b0);
        pend[2] = 1'b1;
        step();
        chk_req("R11 nothing recorded", 1'b1, 2);
        pend[2] = 1'b0;
        step();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable();
        t_global();
        t_prio();
        t_tie();
        t_nest();
        t_hold();
        t_withdraw();
        t_spurious();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule